// File: doc/BRIEF.md
# Write Burst Release Gate with Programmable Fill Threshold

This block sits beside a write-data FIFO and decides when a buffered write burst may start moving downstream. Beats of a burst keep flowing into the FIFO, but the gate holds the downstream valid low until the burst is worth sending. Three events can open the gate, and the first one to occur wins. The first is the burst's final beat being present in the FIFO. The second is the FIFO being full. The third is the FIFO holding more beats than a software-set threshold.

Once the gate opens, it stays open until the final beat of that burst has left the FIFO. It then closes and judges the next burst from scratch. The FIFO storage is outside this block. The block takes the FIFO's fill level, full flag, head-of-queue last flag and push strobes as inputs. It returns the gated downstream valid and the pop strobe.

The threshold register exists only when the FIFO depth is 4 or more. For smaller depths, only the final-beat and full events can open the gate.

Top module: `wdRelGate`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `relOpen` and `dnVld` are 0. The threshold register resets to `TM_INIT` (default `DEPTH`).
- R2: `dnVld` is 1 only when `fifoOutVld` is 1 and `relOpen` is 1. `fifoPop` is 1 only when `dnVld` and `dnRdy` are both 1. No beat leaves while the gate is shut.
- R3: From the cycle after a beat is pushed with `pushLast`=1, and while that beat is still in the FIFO, `relOpen` is 1.
- R4: In any cycle where `fifoFull` is 1, `relOpen` is 1 in that same cycle.
- R5: In any cycle where `fillLevel` is strictly greater than the threshold, `relOpen` is 1. A `fillLevel` equal to the threshold does not open the gate.
- R6: A write with `tmWrEn`=1 loads `tmWrData` into the threshold register. The new value applies from the next cycle onward.
- R7: Once `relOpen` is 1, it stays 1 until a cycle in which a beat with `popLast`=1 is popped. From the next cycle, the gate is re-evaluated from the conditions in R3 to R5 alone, for the next burst.
- R8: A threshold at or above `DEPTH` never opens the gate. Only the conditions in R3 and R4 can then open it.
- R9: The gate neither drops nor reorders beats. Every beat that is pushed is popped once, in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmWrEn | input | 1 | Threshold register write strobe |
| tmWrData | input | $clog2(DEPTH+1) | Threshold value to load |
| pushEn | input | 1 | A beat enters the FIFO this cycle |
| pushLast | input | 1 | The beat being pushed ends its burst |
| fillLevel | input | $clog2(DEPTH+1) | Current FIFO occupancy |
| fifoFull | input | 1 | FIFO full flag |
| fifoOutVld | input | 1 | FIFO head holds a beat |
| popLast | input | 1 | The FIFO head beat ends its burst |
| dnRdy | input | 1 | Downstream ready |
| dnVld | output | 1 | Gated downstream valid |
| fifoPop | output | 1 | Pop strobe back to the FIFO |
| relOpen | output | 1 | Release enable for the current head burst |

## Verification
The three opening events do not all take effect at the same time:
- Full and over-threshold open the gate in the same cycle, because they are read straight from the occupancy inputs.
- A pushed final beat opens it one cycle after its push edge, once the buffered final-beat count has been registered.
- A threshold write takes effect one cycle after its edge.
- Closing after the final beat pops also happens one cycle after that pop edge.

The bench keeps its own FIFO model and release model. Both are updated on the rising edge from the values held just before it. `relOpen` and `dnVld` are compared at every falling edge, so every expected value lines up with the cycle in which it is due.

// File: rtl/wdgPkg.sv
package wdgPkg;

  // Reasons the gate may open for the head burst.
  typedef struct packed {
    logic lastHeld;   // a burst-ending beat sits in the FIFO
    logic fillFull;   // the FIFO has no free slot
    logic overMark;   // occupancy is above the threshold
  } relCause_t;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic popBeat;    // a beat leaves the FIFO this cycle
    logic popLast;    // the head beat ends its burst
  } ctlStrobe_t;

  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gateState_t;

endpackage

// File: rtl/wdgDatapath.sv
module wdgDatapath
  import wdgPkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TM_INIT = DEPTH,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tmWrEn,
  input  logic [LW-1:0]    tmWrData,
  input  logic             pushEn,
  input  logic             pushLast,
  input  logic [LW-1:0]    fillLevel,
  input  logic             fifoFull,
  input  ctlStrobe_t       strobe,
  output relCause_t        cause
);

  localparam logic [LW-1:0] ONE = LW'(1);

  logic [LW-1:0] lastCnt;
  logic          lastIn;
  logic          lastOut;

  assign lastIn  = pushEn & pushLast;
  assign lastOut = strobe.popBeat & strobe.popLast;

  // Count of burst-ending beats currently buffered in the FIFO.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCnt <= '0;
    end else begin
      case ({lastIn, lastOut})
        2'b10:   lastCnt <= lastCnt + ONE;
        2'b01:   lastCnt <= lastCnt - ONE;
        default: lastCnt <= lastCnt;
      endcase
    end
  end

  assign cause.lastHeld = (lastCnt != '0);
  assign cause.fillFull = fifoFull;

  generate
    if (DEPTH >= 4) begin : gMark
      logic [LW-1:0] tmReg;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tmReg <= LW'(TM_INIT);
        end else if (tmWrEn) begin
          tmReg <= tmWrData;
        end
      end

      assign cause.overMark = (fillLevel > tmReg);
    end else begin : gNoMark
      assign cause.overMark = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/wdgCtrl.sv
module wdgCtrl
  import wdgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  relCause_t  cause,
  input  logic       fifoOutVld,
  input  logic       popLast,
  input  logic       dnRdy,
  output logic       dnVld,
  output logic       fifoPop,
  output logic       relOpen,
  output ctlStrobe_t strobe
);

  gateState_t stateQ, stateD;
  logic       anyCause;
  logic       burstDone;

  assign anyCause  = |cause;
  assign relOpen   = (stateQ == GATE_OPEN) | anyCause;
  assign dnVld     = fifoOutVld & relOpen;
  assign fifoPop   = dnVld & dnRdy;
  assign burstDone = fifoPop & popLast;

  assign strobe.popBeat = fifoPop;
  assign strobe.popLast = popLast;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      GATE_SHUT: if (anyCause && !burstDone) stateD = GATE_OPEN;
      GATE_OPEN: if (burstDone)              stateD = GATE_SHUT;
      default:                               stateD = GATE_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= GATE_SHUT;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/wdRelGate.sv
module wdRelGate
  import wdgPkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TM_INIT = DEPTH,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tmWrEn,
  input  logic [LW-1:0] tmWrData,
  input  logic          pushEn,
  input  logic          pushLast,
  input  logic [LW-1:0] fillLevel,
  input  logic          fifoFull,
  input  logic          fifoOutVld,
  input  logic          popLast,
  input  logic          dnRdy,
  output logic          dnVld,
  output logic          fifoPop,
  output logic          relOpen
);

  relCause_t  cause;
  ctlStrobe_t strobe;

  wdgDatapath #(.DEPTH(DEPTH), .TM_INIT(TM_INIT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .tmWrEn   (tmWrEn),
    .tmWrData (tmWrData),
    .pushEn   (pushEn),
    .pushLast (pushLast),
    .fillLevel(fillLevel),
    .fifoFull (fifoFull),
    .strobe   (strobe),
    .cause    (cause)
  );

  wdgCtrl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cause     (cause),
    .fifoOutVld(fifoOutVld),
    .popLast   (popLast),
    .dnRdy     (dnRdy),
    .dnVld     (dnVld),
    .fifoPop   (fifoPop),
    .relOpen   (relOpen),
    .strobe    (strobe)
  );

endmodule

// File: rtl/wdRelGateChk.sv
module wdRelGateChk (
  input logic clk,
  input logic rstN,
  input logic pushEn,
  input logic pushLast,
  input logic fifoFull,
  input logic popLast,
  input logic dnVld,
  input logic fifoPop,
  input logic relOpen
);

  AST_SHUT_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !relOpen |-> !dnVld);                                              // R2

  AST_POP_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> relOpen);                                              // R2

  AST_LAST_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && pushLast) |=> relOpen);                                 // R3

  AST_FULL_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> relOpen);                                             // R4

  AST_HOLD_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (relOpen && !(fifoPop && popLast)) |=> relOpen);                   // R7

endmodule

bind wdRelGate wdRelGateChk chk (
  .clk     (clk),
  .rstN    (rstN),
  .pushEn  (pushEn),
  .pushLast(pushLast),
  .fifoFull(fifoFull),
  .popLast (popLast),
  .dnVld   (dnVld),
  .fifoPop (fifoPop),
  .relOpen (relOpen)
);

// File: tb/wdRelGate_test.sv
module wdRelGate_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LW         = $clog2(DEPTH + 1);

  typedef struct {
    int id;
    int idx;
    bit last;
  } beat_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tmWrEn = 1'b0;
  logic [LW-1:0] tmWrData = '0;
  logic          pushEn = 1'b0;
  logic          pushLast = 1'b0;
  logic [LW-1:0] fillLevel = '0;
  logic          fifoFull = 1'b0;
  logic          fifoOutVld = 1'b0;
  logic          popLast = 1'b0;
  logic          dnRdy = 1'b0;
  logic          dnVld, fifoPop, relOpen;

  beat_t fifoQ[$];
  beat_t expQ[$];
  beat_t curBeat;
  int    vectors = 0;
  int    miscompares = 0;
  int    tmM = DEPTH;
  bit    openM = 1'b0;
  int    cycles = 0;
  bit    done = 1'b0;

  wdRelGate #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .tmWrEn(tmWrEn), .tmWrData(tmWrData),
    .pushEn(pushEn), .pushLast(pushLast), .fillLevel(fillLevel),
    .fifoFull(fifoFull), .fifoOutVld(fifoOutVld), .popLast(popLast),
    .dnRdy(dnRdy), .dnVld(dnVld), .fifoPop(fifoPop), .relOpen(relOpen)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit anyLastM();
    foreach (fifoQ[i]) if (fifoQ[i].last) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit trigM();
    return anyLastM() || (fifoQ.size() == DEPTH) || (fifoQ.size() > tmM);
  endfunction

  function automatic string tagM();
    if (fifoQ.size() == DEPTH) return "R4";
    if (anyLastM())            return "R3";
    if (fifoQ.size() > tmM)    return "R5";
    if (openM)                 return "R7";
    return "R8";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // FIFO model plus release model, updated from pre-edge values.
  always @(posedge clk) begin
    bit    p, pl, tr;
    beat_t b, e;
    p  = fifoPop;
    pl = popLast;
    tr = trigM();
    if (!rstN) begin
      fifoQ.delete();
      openM = 1'b0;
      tmM   = DEPTH;
    end else begin
      if (p) begin
        check(openM || tr, "R2 beat left while gate shut", 1, 0);
        b = fifoQ.pop_front();
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected beat", b.idx, -1);
        end else begin
          e = expQ.pop_front();
          check(b.id == e.id && b.idx == e.idx, "R9 beat order", b.id * 100 + b.idx, e.id * 100 + e.idx);
        end
      end
      openM = (openM || tr) && !(p && pl);
      if (pushEn) fifoQ.push_back(curBeat);
      if (tmWrEn) tmM = int'(tmWrData);
    end
    fillLevel  <= LW'(fifoQ.size());
    fifoFull   <= (fifoQ.size() == DEPTH);
    fifoOutVld <= (fifoQ.size() > 0);
    popLast    <= (fifoQ.size() > 0) ? fifoQ[0].last : 1'b0;
  end

  // Monitor: compare gate outputs with the model every cycle.
  always @(negedge clk) begin
    bit expOpen;
    if (rstN && !done) begin
      expOpen = openM || trigM();
      check(relOpen == expOpen, tagM(), int'(relOpen), int'(expOpen));
      check(dnVld == (fifoOutVld && expOpen), "R2 gated valid", int'(dnVld), int'(fifoOutVld && expOpen));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
      summary();
      $finish;
    end
  end

  task automatic pushBeat(int id, int idx, bit last);
    while (fifoQ.size() >= DEPTH) @(negedge clk);
    curBeat = '{id, idx, last};
    expQ.push_back(curBeat);
    pushEn   = 1'b1;
    pushLast = last;
    @(negedge clk);
    pushEn   = 1'b0;
    pushLast = 1'b0;
  endtask

  task automatic writeMark(int v);
    tmWrEn   = 1'b1;
    tmWrData = LW'(v);
    @(negedge clk);
    tmWrEn   = 1'b0;
  endtask

  task automatic drain();
    dnRdy = 1'b1;
    while (fifoQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(relOpen == 1'b0, "R1 relOpen in reset", int'(relOpen), 0);
    check(dnVld == 1'b0, "R1 dnVld in reset", int'(dnVld), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(relOpen == 1'b0, "R1 relOpen after reset", int'(relOpen), 0);

    // Single-beat burst: opens the cycle after its push, closes after it leaves.
    dnRdy = 1'b1;
    pushBeat(1, 0, 1'b1);
    check(relOpen == 1'b1, "R3 single beat release", int'(relOpen), 1);
    @(negedge clk);
    check(relOpen == 1'b0, "R7 re-armed after single beat", int'(relOpen), 0);

    // Long burst, default threshold = DEPTH: only full opens it.
    dnRdy = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) pushBeat(2, i, 1'b0);
    check(relOpen == 1'b0, "R8 threshold at depth ignored", int'(relOpen), 0);
    check(dnVld == 1'b0, "R2 held beats not offered", int'(dnVld), 0);
    pushBeat(2, DEPTH - 1, 1'b0);
    check(relOpen == 1'b1, "R4 full opens", int'(relOpen), 1);
    dnRdy = 1'b1;
    while (fifoQ.size() != 0) @(negedge clk);
    check(relOpen == 1'b1, "R7 held open on empty FIFO", int'(relOpen), 1);
    pushBeat(2, DEPTH, 1'b0);
    pushBeat(2, DEPTH + 1, 1'b1);
    drain();
    check(relOpen == 1'b0, "R7 closed after long burst", int'(relOpen), 0);

    // Short burst against threshold 2.
    writeMark(2);
    pushBeat(3, 0, 1'b0);
    @(negedge clk);
    pushBeat(3, 1, 1'b0);
    @(negedge clk);
    check(relOpen == 1'b0, "R5 level equal to threshold", int'(relOpen), 0);
    pushBeat(3, 2, 1'b0);
    check(relOpen == 1'b1, "R5 level above threshold", int'(relOpen), 1);
    pushBeat(3, 3, 1'b0);
    pushBeat(3, 4, 1'b1);
    drain();

    // Threshold change applies one cycle after the write.
    dnRdy = 1'b0;
    writeMark(3);
    pushBeat(4, 0, 1'b0);
    pushBeat(4, 1, 1'b0);
    check(relOpen == 1'b0, "R6 below new threshold", int'(relOpen), 0);
    tmWrEn   = 1'b1;
    tmWrData = LW'(1);
    @(negedge clk);
    tmWrEn   = 1'b0;
    check(relOpen == 1'b1, "R6 lowered threshold applies", int'(relOpen), 1);
    pushBeat(4, 2, 1'b0);
    pushBeat(4, 3, 1'b1);
    drain();

    // Re-arm: complete bursts pass, the following partial burst is held.
    dnRdy = 1'b0;
    writeMark(DEPTH);
    pushBeat(5, 0, 1'b0);
    pushBeat(5, 1, 1'b1);
    pushBeat(6, 0, 1'b1);
    pushBeat(7, 0, 1'b0);
    dnRdy = 1'b1;
    while (fifoQ.size() > 1) @(negedge clk);
    @(negedge clk);
    check(relOpen == 1'b0, "R7 next partial burst held", int'(relOpen), 0);
    check(dnVld == 1'b0, "R2 partial burst not offered", int'(dnVld), 0);
    pushBeat(7, 1, 1'b0);
    pushBeat(7, 2, 1'b1);
    drain();

    check(expQ.size() == 0, "R9 all beats forwarded", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule